// File: doc/BRIEF.md
# Shared Atomic Word Store

This block is a small word-addressed memory shared by several requesters, such as threads or cores. Each requester can issue a plain load, a plain store, or one of five indivisible read-modify-write operations: conditional store (compare-and-swap), unconditional exchange, fetch-add, fetch-or and fetch-and. A round-robin arbiter accepts at most one request per cycle. The accepted request reads its word, changes it and writes it back within that same cycle. As a result, requests that arrive together, such as several lock attempts on one word, always take effect one after another, and exactly one of them can win.

Each requester has its own valid/ready request lane. Responses come back on a shared bus: a per-requester one-hot valid, the requester's ID, the value the word held before the operation, and a hit flag for a successful compare-and-swap. A lock word holds 0 when free and 1 when held. A requester takes the lock with a compare-and-swap from 0 to 1, or with an exchange of 1 that returns 0. It releases the lock with a plain store of 0.

Top module: `atomic_mem_unit`

## Requirements
- R1: After reset every memory word reads 0, and no response valid or request ready is asserted.
- R2: At most one request is accepted per cycle. A ready is only given to a requester whose valid is high. When several valids are high together, exactly one is accepted in that cycle.
- R3: Arbitration is round-robin. After requester i is accepted, the search for the next winner starts at requester i+1 and wraps. A requester that keeps its valid high is accepted within NUM_REQ cycles.
- R4: The response comes exactly one cycle after acceptance. In that cycle, bit i of rspValid is high for requester i only, rspId equals i, and rspData holds the word's value before the operation.
- R5: A load (op code 0) leaves the word unchanged. A store (op code 1) writes reqData. Both return the prior value.
- R6: Compare-and-swap (op code 2) writes reqData only when the stored word equals reqCmp. It returns the prior word, not reqCmp, and raises rspHit only when the two matched.
- R7: Exchange (op code 3) always writes reqData and returns the prior word.
- R8: Fetch-add (op code 4) writes the prior word plus reqData, wrapping modulo 2^DATA_W.
- R9: Fetch-or (op code 5) and fetch-and (op code 6) write the prior word OR or AND reqData.
- R10: Each accepted request sees the results of every earlier accepted request, including a store from the same requester. Concurrent read-modify-writes to one word never lose an update.
- R11: The reserved op code 7 acts as a load: it returns the word and leaves it unchanged.
- R12: When all requesters issue compare-and-swap 0 to 1 on a free lock word together, exactly one gets rspHit and prior 0. The others read 1 until a store of 0 releases the lock, after which an exchange of 1 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Request valid, one bit per requester |
| reqReady | output | NUM_REQ | Request accepted this cycle, one-hot or zero |
| reqOp | input | 3*NUM_REQ | Op code per requester |
| reqAddr | input | ADDR_W*NUM_REQ | Word address per requester |
| reqCmp | input | DATA_W*NUM_REQ | Expected value for compare-and-swap |
| reqData | input | DATA_W*NUM_REQ | Store value or operand |
| rspValid | output | NUM_REQ | Response valid, one-hot per requester |
| rspId | output | ID_W | ID of the requester being answered |
| rspData | output | DATA_W | Word value before the operation |
| rspHit | output | 1 | Compare-and-swap matched |

## Verification
Ready depends only on the current valids and the arbiter pointer. The bench drives inputs at the falling edge and reads reqReady just after, so it knows which rising edge will accept each request. The response is due at the next falling edge, and the bench checks rspValid, rspId, rspData and rspHit there and nowhere else. Memory effects are checked with a later load. The cycle in which each request is accepted is recorded, so round-robin order shows as consecutive cycle numbers.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_CAS   = 3'd2,
    OP_SWAP  = 3'd3,
    OP_ADD   = 3'd4,
    OP_OR    = 3'd5,
    OP_AND   = 3'd6,
    OP_RSVD  = 3'd7
  } amu_op_e;

  localparam int OP_W = $bits(amu_op_e);

  // strobes from control to datapath for the granted request
  typedef struct packed {
    logic    fire;
    amu_op_e op;
  } amu_strobe_t;
endpackage

// File: rtl/amu_rr_arbiter.sv
module amu_rr_arbiter #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grantIdx,
  output logic          anyGrant
);
  logic [IW-1:0] ptr;

  always_comb begin
    grant    = '0;
    grantIdx = '0;
    anyGrant = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!anyGrant && req[(int'(ptr) + k) % N]) begin
        anyGrant = 1'b1;
        grant[(int'(ptr) + k) % N] = 1'b1;
        grantIdx = IW'((int'(ptr) + k) % N);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (anyGrant) begin
      if (int'(grantIdx) == N - 1) ptr <= '0;
      else                         ptr <= grantIdx + 1'b1;
    end
  end

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
  p_grant_when_any_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> anyGrant);

  // starvation watch: cycles a requester has waited with valid held
  generate
    for (genvar i = 0; i < N; i++) begin : g_wait
      logic [IW:0] waitCnt;
      always_ff @(posedge clk) begin
        if (!rst_n) waitCnt <= '0;
        else if (req[i] && !grant[i]) begin
          if (waitCnt != '1) waitCnt <= waitCnt + 1'b1;
        end else waitCnt <= '0;
      end
      p_bounded_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(waitCnt) < N);
    end
  endgenerate
endmodule

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      reqValid,
  input  logic [N*OP_W-1:0] reqOp,
  output logic [N-1:0]      reqReady,
  output amu_strobe_t       strobe,
  output logic [IW-1:0]     grantIdx,
  output logic [N-1:0]      rspValid,
  output logic [IW-1:0]     rspId
);
  logic anyGrant;

  amu_rr_arbiter #(.N(N)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (reqValid),
    .grant    (reqReady),
    .grantIdx (grantIdx),
    .anyGrant (anyGrant)
  );

  always_comb begin
    strobe.fire = anyGrant;
    strobe.op   = amu_op_e'(reqOp[int'(grantIdx)*OP_W +: OP_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= '0;
      rspId    <= '0;
    end else begin
      rspValid <= reqReady;
      if (anyGrant) rspId <= grantIdx;
    end
  end
endmodule

// File: rtl/amu_datapath.sv
module amu_datapath
  import amu_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int DW = 32,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  amu_strobe_t     strobe,
  input  logic [IW-1:0]   grantIdx,
  input  logic [N*AW-1:0] reqAddr,
  input  logic [N*DW-1:0] reqCmp,
  input  logic [N*DW-1:0] reqData,
  output logic [DW-1:0]   rspData,
  output logic            rspHit
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selCmp, selData, prior, newVal;
  logic          wrEn, match;

  always_comb begin
    selAddr = reqAddr[int'(grantIdx)*AW +: AW];
    selCmp  = reqCmp[int'(grantIdx)*DW +: DW];
    selData = reqData[int'(grantIdx)*DW +: DW];
    prior   = mem[selAddr];
    match   = (prior == selCmp);
    newVal  = prior;
    wrEn    = 1'b0;
    unique case (strobe.op)
      OP_WRITE: begin newVal = selData;          wrEn = 1'b1;  end
      OP_CAS:   begin newVal = selData;          wrEn = match; end
      OP_SWAP:  begin newVal = selData;          wrEn = 1'b1;  end
      OP_ADD:   begin newVal = prior + selData;  wrEn = 1'b1;  end
      OP_OR:    begin newVal = prior | selData;  wrEn = 1'b1;  end
      OP_AND:   begin newVal = prior & selData;  wrEn = 1'b1;  end
      default:  begin newVal = prior;            wrEn = 1'b0;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      rspData <= '0;
      rspHit  <= 1'b0;
    end else begin
      if (strobe.fire && wrEn) mem[selAddr] <= newVal;
      if (strobe.fire) begin
        rspData <= prior;
        rspHit  <= (strobe.op == OP_CAS) && match;
      end else begin
        rspHit  <= 1'b0;
      end
    end
  end

  p_cas_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.op == OP_CAS && !match)
      |=> mem[$past(selAddr)] == $past(prior));
  p_load_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && (strobe.op == OP_READ || strobe.op == OP_RSVD))
      |=> mem[$past(selAddr)] == $past(prior));
  p_rsp_prior_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire |=> rspData == $past(prior));
endmodule

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit
  import amu_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  localparam int ID_W   = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_REQ-1:0]       reqValid,
  output logic [NUM_REQ-1:0]       reqReady,
  input  logic [NUM_REQ*3-1:0]     reqOp,
  input  logic [NUM_REQ*ADDR_W-1:0] reqAddr,
  input  logic [NUM_REQ*DATA_W-1:0] reqCmp,
  input  logic [NUM_REQ*DATA_W-1:0] reqData,
  output logic [NUM_REQ-1:0]       rspValid,
  output logic [ID_W-1:0]          rspId,
  output logic [DATA_W-1:0]        rspData,
  output logic                     rspHit
);
  amu_strobe_t   strobe;
  logic [ID_W-1:0] grantIdx;

  amu_ctrl #(.N(NUM_REQ)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqReady (reqReady),
    .strobe   (strobe),
    .grantIdx (grantIdx),
    .rspValid (rspValid),
    .rspId    (rspId)
  );

  amu_datapath #(.N(NUM_REQ), .AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .grantIdx (grantIdx),
    .reqAddr  (reqAddr),
    .reqCmp   (reqCmp),
    .reqData  (reqData),
    .rspData  (rspData),
    .rspHit   (rspHit)
  );

  p_rsp_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rspValid));
  p_rsp_next_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid != '0) |=> rspValid == $past(reqValid & reqReady));
  p_hit_only_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rspHit |-> rspValid != '0);
endmodule

// File: tb/atomic_mem_unit_bench.sv
module atomic_mem_unit_bench;
  localparam int N = 4, AW = 4, DW = 32;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] reqValid = '0;
  logic [N-1:0] reqReady;
  logic [N*3-1:0] reqOp = '0;
  logic [N*AW-1:0] reqAddr = '0;
  logic [N*DW-1:0] reqCmp = '0, reqData = '0;
  logic [N-1:0] rspValid;
  logic [1:0] rspId;
  logic [DW-1:0] rspData;
  logic rspHit;

  int errors = 0, checks = 0, cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  atomic_mem_unit #(.NUM_REQ(N), .ADDR_W(AW), .DATA_W(DW)) u_atomic_mem_unit (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqAddr(reqAddr), .reqCmp(reqCmp), .reqData(reqData),
    .rspValid(rspValid), .rspId(rspId), .rspData(rspData), .rspHit(rspHit));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request, wait for acceptance, check the response next cycle
  task automatic issue(input int r, input logic [2:0] op, input logic [AW-1:0] addr,
                       input logic [DW-1:0] cmp, input logic [DW-1:0] data,
                       output logic [DW-1:0] prior, output logic hit, output int acc);
    @(negedge clk);
    reqOp[r*3 +: 3] = op;
    reqAddr[r*AW +: AW] = addr;
    reqCmp[r*DW +: DW] = cmp;
    reqData[r*DW +: DW] = data;
    reqValid[r] = 1'b1;
    forever begin
      #1;
      if (reqReady[r]) break;
      @(negedge clk);
    end
    acc = cyc;
    @(negedge clk);
    reqValid[r] = 1'b0;
    chk(rspValid == N'(1 << r), "R4 rspValid", 32'(rspValid), 32'(1 << r));
    chk(int'(rspId) == r, "R4 rspId", 32'(rspId), 32'(r));
    prior = rspData;
    hit = rspHit;
  endtask

  task automatic op1(input int r, input logic [2:0] op, input logic [AW-1:0] addr,
                     input logic [DW-1:0] cmp, input logic [DW-1:0] data,
                     input logic [DW-1:0] expPrior, input string tag);
    logic [DW-1:0] p; logic h; int a;
    issue(r, op, addr, cmp, data, p, h, a);
    chk(p == expPrior, tag, p, expPrior);
  endtask

  task automatic test_reset();
    chk(rspValid == '0, "R1 rspValid at reset", 32'(rspValid), 0);
    chk(reqReady == '0, "R1 reqReady idle", 32'(reqReady), 0);
    op1(0, 3'd0, 4'd3, 0, 0, 32'h0, "R1 word 3 zero");
    op1(3, 3'd0, 4'd15, 0, 0, 32'h0, "R1 word 15 zero");
  endtask

  task automatic test_plain();
    op1(1, 3'd1, 4'd2, 0, 32'h1234, 32'h0, "R5 store prior");
    op1(1, 3'd0, 4'd2, 0, 0, 32'h1234, "R5 load after store");
    op1(2, 3'd0, 4'd2, 0, 0, 32'h1234, "R5 load leaves word");
  endtask

  task automatic test_cas();
    logic [DW-1:0] p; logic h; int a;
    issue(0, 3'd2, 4'd2, 32'h1111, 32'h5, p, h, a);
    chk(p == 32'h1234, "R6 miss returns prior", p, 32'h1234);
    chk(h == 1'b0, "R6 miss no hit", 32'(h), 0);
    op1(0, 3'd0, 4'd2, 0, 0, 32'h1234, "R6 miss keeps word");
    issue(0, 3'd2, 4'd2, 32'h1234, 32'h55, p, h, a);
    chk(p == 32'h1234, "R6 match returns prior", p, 32'h1234);
    chk(h == 1'b1, "R6 match hit", 32'(h), 1);
    op1(0, 3'd0, 4'd2, 0, 0, 32'h55, "R6 match writes");
  endtask

  task automatic test_swap_add_bits();
    op1(3, 3'd3, 4'd4, 0, 32'hABCD, 32'h0, "R7 swap prior 0");
    op1(3, 3'd3, 4'd4, 0, 32'h1, 32'hABCD, "R7 swap prior");
    op1(1, 3'd1, 4'd6, 0, 32'hFFFFFFFF, 32'h0, "R8 setup");
    op1(1, 3'd4, 4'd6, 0, 32'h2, 32'hFFFFFFFF, "R8 add prior");
    op1(1, 3'd0, 4'd6, 0, 0, 32'h1, "R8 add wraps");
    op1(2, 3'd1, 4'd7, 0, 32'hF0F0, 32'h0, "R9 setup");
    op1(2, 3'd5, 4'd7, 0, 32'h000F, 32'hF0F0, "R9 or prior");
    op1(2, 3'd6, 4'd7, 0, 32'h0F0F, 32'hF0FF, "R9 and prior");
    op1(2, 3'd0, 4'd7, 0, 0, 32'h000F, "R9 or/and result");
    op1(0, 3'd7, 4'd7, 0, 32'hDEAD, 32'h000F, "R11 reserved returns word");
    op1(0, 3'd0, 4'd7, 0, 0, 32'h000F, "R11 reserved leaves word");
  endtask

  task automatic test_order();
    logic [DW-1:0] p[N]; logic h[N]; int a[N];
    op1(2, 3'd1, 4'd8, 0, 32'h77, 32'h0, "R10 store");
    op1(2, 3'd4, 4'd8, 0, 32'h3, 32'h77, "R10 add sees own store");
    fork
      issue(0, 3'd4, 4'd8, 0, 32'd1, p[0], h[0], a[0]);
      issue(1, 3'd4, 4'd8, 0, 32'd2, p[1], h[1], a[1]);
      issue(2, 3'd4, 4'd8, 0, 32'd3, p[2], h[2], a[2]);
      issue(3, 3'd4, 4'd8, 0, 32'd4, p[3], h[3], a[3]);
    join
    op1(0, 3'd0, 4'd8, 0, 0, 32'h84, "R10 concurrent adds no loss");
    op1(1, 3'd1, 4'd9, 0, 32'hF0, 32'h0, "R10 setup bits");
    fork
      issue(0, 3'd5, 4'd9, 0, 32'h1, p[0], h[0], a[0]);
      issue(1, 3'd5, 4'd9, 0, 32'h2, p[1], h[1], a[1]);
      issue(2, 3'd6, 4'd9, 0, 32'hFFFFFF7F, p[2], h[2], a[2]);
      issue(3, 3'd5, 4'd9, 0, 32'h4, p[3], h[3], a[3]);
    join
    op1(1, 3'd0, 4'd9, 0, 0, 32'h77, "R10 R9 concurrent or/and combine");
  endtask

  task automatic test_rr();
    logic [DW-1:0] p[N]; logic h[N]; int a[N];
    op1(1, 3'd0, 4'd0, 0, 0, 32'h0, "R3 prime pointer");
    fork
      issue(0, 3'd0, 4'd0, 0, 0, p[0], h[0], a[0]);
      issue(1, 3'd0, 4'd0, 0, 0, p[1], h[1], a[1]);
      issue(2, 3'd0, 4'd0, 0, 0, p[2], h[2], a[2]);
      issue(3, 3'd0, 4'd0, 0, 0, p[3], h[3], a[3]);
    join
    chk(a[3] == a[2] + 1, "R3 R2 order 2 then 3", 32'(a[3] - a[2]), 1);
    chk(a[0] == a[3] + 1, "R3 order 3 then 0", 32'(a[0] - a[3]), 1);
    chk(a[1] == a[0] + 1, "R3 order 0 then 1", 32'(a[1] - a[0]), 1);
  endtask

  task automatic test_lock();
    logic [DW-1:0] p[N]; logic h[N]; int a[N];
    int hits = 0, w = 0, l;
    fork
      issue(0, 3'd2, 4'd10, 0, 1, p[0], h[0], a[0]);
      issue(1, 3'd2, 4'd10, 0, 1, p[1], h[1], a[1]);
      issue(2, 3'd2, 4'd10, 0, 1, p[2], h[2], a[2]);
      issue(3, 3'd2, 4'd10, 0, 1, p[3], h[3], a[3]);
    join
    for (int i = 0; i < N; i++) begin
      if (h[i]) begin hits++; w = i; end
    end
    chk(hits == 1, "R12 exactly one winner", 32'(hits), 1);
    for (int i = 0; i < N; i++) begin
      if (i == w) chk(p[i] == 0, "R12 winner saw free", p[i], 0);
      else        chk(p[i] == 1, "R12 loser saw held", p[i], 1);
    end
    l = (w + 1) % N;
    op1(l, 3'd2, 4'd10, 0, 32'h1, 32'h1, "R12 retry still held");
    op1(w, 3'd1, 4'd10, 0, 32'h0, 32'h1, "R12 release");
    op1(l, 3'd3, 4'd10, 0, 32'h1, 32'h0, "R12 exchange acquires");
    op1(w, 3'd0, 4'd10, 0, 0, 32'h1, "R12 lock held again");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    test_reset();
    test_plain();
    test_cas();
    test_swap_add_bits();
    test_order();
    test_rr();
    test_lock();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule